// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the device side of a synchronous DRAM interface. On every rising clock edge it samples the control pins: chip select, the three command strobes, the clock enable for the current and the previous cycle, the bank select and the address. It turns them into one command code per cycle. Commands are told apart by the strobe pattern, by bit 10 of the address, and by how the clock enable moved between the two cycles.

From these commands it keeps a model of the device. It tracks which of the banks hold an open row and which row that is. It tracks whether the device is in normal operation, in self-refresh, or has its clock suspended. It also raises a one-cycle flag for any command that the current bank state forbids.

All outputs are registered. A command sampled at edge k is visible on the outputs just after edge k. The storage array, the data bursts and analog timing are outside this block. The only burst effect modelled is the delayed close of a bank after a read or write that has auto-precharge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With the clock enable high in the previous cycle and the device not in self-refresh, a high chip select gives code 0 (deselect) whatever the strobes are, and it never sets the illegal flag.
- R2: With chip select low, the strobe pattern {ras_n,cas_n,we_n} decodes as follows:
  - 111 is NOP (1) and 011 is activate (2).
  - 101 is read (3), or read with auto-precharge (4) when addr[10] is high.
  - 100 is write (5), or write with auto-precharge (6) when addr[10] is high.
  - 010 is precharge (7), or precharge-all (8) when addr[10] is high.
  - 110 is burst terminate (9) and 000 is mode register set (10).
- R3: Pattern 001 is auto-refresh (11) when the clock enable is high in both cycles. It is self-refresh entry (12) when the clock enable falls in the current cycle, and after entry the power state reads 1 (self-refresh).
- R4: In self-refresh, the code is 14 (held) and the state stays for as long as the clock enable stays low. A low-to-high clock enable together with deselect or a NOP pattern gives code 13 (exit) and power state 0. A return with any other pattern sets the illegal flag and stays in self-refresh.
- R5: Precharge closes only the bank selected by ba. Precharge-all closes every bank.
- R6: Activate on an idle bank marks it active and stores addr[11:0] in open_rows[b*12 +: 12].
- R7: Read or write with auto-precharge on an active bank leaves it active for BURST_LEN-1 further edges. The bank reads idle after the BURST_LEN-th edge that follows the command.
- R8: Read or write to an idle bank, and activate to an active bank, set the illegal flag and change no bank or row state.
- R9: Mode register set is legal only when every bank is idle. Otherwise it sets the illegal flag.
- R10: Auto-refresh and self-refresh entry leave every bank idle.
- R11: In normal operation, a low clock enable gives power state 2 (suspended) on the next output. A cycle whose previous clock enable is low gives code 14, and the command pins have no effect on the banks.
- R12: A synchronous active-high reset makes all banks idle, all rows 0, the power state 0, the code 0 and the illegal flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke_prev | input | 1 | Clock enable sampled in the previous cycle |
| cke | input | 1 | Clock enable in the current cycle |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address; bit 10 is the precharge option |
| cmd_q | output | 4 | Decoded command code (R2 to R4 encodings) |
| illegal_q | output | 1 | Illegal command seen at the last edge |
| bank_active | output | 4 | One bit per bank, 1 = row open |
| open_rows | output | 48 | Stored row per bank, bank b at bits b*12 +: 12 |
| pwr_q | output | 2 | 0 normal, 1 self-refresh, 2 clock suspended |

## Verification
A wrong bank bit shows up at the ports in one of two ways. It can show at once on bank_active. Or it can stay hidden until a later read, write or activate to that bank flags (or fails to flag) illegal_q. The behavioural model therefore compares every output on every cycle, so a divergence is caught on the edge it happens. A stale auto-precharge counter only shows BURST_LEN edges later, as a bank that closes too early or too late. The directed sequence steps through that window one edge at a time. A wrong power state shows as wrong command codes from the very next cycle, because the decoder depends on it.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_ACT    = 4'd2,
    CMD_READ   = 4'd3,
    CMD_READA  = 4'd4,
    CMD_WRITE  = 4'd5,
    CMD_WRITEA = 4'd6,
    CMD_PRE    = 4'd7,
    CMD_PREA   = 4'd8,
    CMD_TERM   = 4'd9,
    CMD_MRS    = 4'd10,
    CMD_REFA   = 4'd11,
    CMD_REFS   = 4'd12,
    CMD_REFSX  = 4'd13,
    CMD_HOLD   = 4'd14
  } cmd_e;

  typedef enum logic [1:0] {
    PW_NORMAL = 2'd0,
    PW_SELF   = 2'd1,
    PW_SUSP   = 2'd2
  } pwr_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_dec_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke_prev,
  input  logic cke,
  input  logic a10,
  input  logic in_self,
  output cmd_e cmd,
  output logic exit_bad
);
  logic nop_pat;
  assign nop_pat = ras_n & cas_n & we_n;

  always_comb begin
    cmd      = CMD_HOLD;
    exit_bad = 1'b0;
    if (in_self) begin
      // only a rising clock enable can leave self-refresh
      if (!cke_prev && cke) begin
        if (cs_n || nop_pat) cmd = CMD_REFSX;
        else                 exit_bad = 1'b1;
      end
    end else if (!cke_prev) begin
      cmd = CMD_HOLD;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = a10 ? CMD_READA  : CMD_READ;
        3'b100:  cmd = a10 ? CMD_WRITEA : CMD_WRITE;
        3'b010:  cmd = a10 ? CMD_PREA   : CMD_PRE;
        3'b110:  cmd = CMD_TERM;
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = cke ? CMD_REFA : CMD_REFS;
        default: cmd = CMD_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/sdram_power_ctl.sv
module sdram_power_ctl
  import sdram_dec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cmd_e cmd,
  input  logic cke,
  output pwr_e pwr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= PW_NORMAL;
    end else if (pwr_q == PW_SELF) begin
      if (cmd == CMD_REFSX) pwr_q <= PW_NORMAL;
    end else if (cmd == CMD_REFS) begin
      pwr_q <= PW_SELF;
    end else begin
      pwr_q <= cke ? PW_NORMAL : PW_SUSP;
    end
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_dec_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  cmd_e                       cmd,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           row_in,
  input  logic                       advance,
  output logic [NUM_BANKS-1:0]       active,
  output logic [NUM_BANKS*ROW_W-1:0] rows,
  output logic                       illegal
);
  localparam int CW = $clog2(BURST_LEN + 1);

  always_comb begin
    case (cmd)
      CMD_ACT:                                     illegal = active[ba];
      CMD_READ, CMD_READA, CMD_WRITE, CMD_WRITEA:  illegal = ~active[ba];
      CMD_MRS:                                     illegal = |active;
      default:                                     illegal = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             act_r;
    logic [CW-1:0]    cnt;
    logic [ROW_W-1:0] row_r;
    logic             hit;
    assign hit = (ba == BA_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        act_r <= 1'b0;
        cnt   <= '0;
        row_r <= '0;
      end else begin
        // auto-precharge countdown runs only on live clock cycles
        if (advance && cnt != '0) begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) act_r <= 1'b0;
        end
        case (cmd)
          CMD_ACT: if (hit && !act_r) begin
            act_r <= 1'b1;
            row_r <= row_in;
            cnt   <= '0;
          end
          CMD_READA, CMD_WRITEA: if (hit && act_r) begin
            act_r <= 1'b1;
            cnt   <= CW'(BURST_LEN);
          end
          CMD_PRE: if (hit) begin
            act_r <= 1'b0;
            cnt   <= '0;
          end
          CMD_PREA, CMD_REFA, CMD_REFS: begin
            act_r <= 1'b0;
            cnt   <= '0;
          end
          default: ;
        endcase
      end
    end

    assign active[g]                = act_r;
    assign rows[g*ROW_W +: ROW_W]   = row_r;
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_dec_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic                       cke_prev,
  input  logic                       cke,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [3:0]                 cmd_q,
  output logic                       illegal_q,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic [1:0]                 pwr_q
);
  pwr_e pwr;
  cmd_e cmd_n;
  logic exit_bad;
  logic bank_ill;

  sdram_cmd_decode u_dec (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cke_prev (cke_prev),
    .cke      (cke),
    .a10      (addr[AP_BIT]),
    .in_self  (pwr == PW_SELF),
    .cmd      (cmd_n),
    .exit_bad (exit_bad)
  );

  sdram_power_ctl u_pwr (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd_n),
    .cke   (cke),
    .pwr_q (pwr)
  );

  sdram_bank_tracker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .BURST_LEN (BURST_LEN)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd_n),
    .ba      (ba),
    .row_in  (addr),
    .advance (cke_prev && (pwr != PW_SELF)),
    .active  (bank_active),
    .rows    (open_rows),
    .illegal (bank_ill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= CMD_DESEL;
      illegal_q <= 1'b0;
    end else begin
      cmd_q     <= cmd_n;
      illegal_q <= exit_bad | bank_ill;
    end
  end

  assign pwr_q = pwr;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [3:0]           cmd_q,
  input logic                 illegal_q,
  input logic [NUM_BANKS-1:0] bank_active,
  input logic [1:0]           pwr_q
);
  AST_DESEL_NEVER_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == 4'd0) |-> !illegal_q); // R1
  AST_SELF_ENTRY_STATE: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == 4'd12) |-> (pwr_q == 2'd1)); // R3
  AST_SELF_BANKS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pwr_q == 2'd1) |-> (bank_active == '0)); // R10
  AST_PREA_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == 4'd8) |-> (bank_active == '0)); // R5
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == 4'd2 && !illegal_q) |-> (bank_active != '0)); // R6
  AST_MRS_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == 4'd10 && !illegal_q) |-> (bank_active == '0)); // R9
  AST_EXIT_TO_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == 4'd13) |-> (pwr_q == 2'd0)); // R4
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_active == '0 && pwr_q == 2'd0)); // R12
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_q       (cmd_q),
  .illegal_q   (illegal_q),
  .bank_active (bank_active),
  .pwr_q       (pwr_q)
);

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/100ps
module sdram_cmd_tracker_tb;
  localparam int NB = 4;
  localparam int RW = 12;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic cke_prev = 1'b1, cke = 1'b1;
  logic [1:0] ba = '0;
  logic [RW-1:0] addr = '0;
  logic [3:0] cmd_q;
  logic illegal_q;
  logic [NB-1:0] bank_active;
  logic [NB*RW-1:0] open_rows;
  logic [1:0] pwr_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .AP_BIT(10), .BURST_LEN(BL)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke_prev(cke_prev), .cke(cke), .ba(ba), .addr(addr),
    .cmd_q(cmd_q), .illegal_q(illegal_q), .bank_active(bank_active),
    .open_rows(open_rows), .pwr_q(pwr_q)
  );

  // ---------------- behavioural reference model ----------------
  int  m_act [NB];
  int  m_cnt [NB];
  int  m_row [NB];
  int  m_pwr;
  int  m_cmd;
  int  m_ill;

  function automatic int mdecode(int self_st, logic cs, logic r, logic c, logic w,
                                 logic ckp, logic ck, logic a10);
    if (self_st == 1) return (!ckp && ck && (cs || (r && c && w))) ? 13 : 14;
    if (!ckp) return 14;
    if (cs) return 0;
    if ( r &&  c &&  w) return 1;
    if (!r &&  c &&  w) return 2;
    if ( r && !c &&  w) return a10 ? 4 : 3;
    if ( r && !c && !w) return a10 ? 6 : 5;
    if (!r &&  c && !w) return a10 ? 8 : 7;
    if ( r &&  c && !w) return 9;
    if (!r && !c && !w) return 10;
    return ck ? 11 : 12;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NB; b++) begin m_act[b] = 0; m_cnt[b] = 0; m_row[b] = 0; end
      m_pwr = 0; m_cmd = 0; m_ill = 0;
    end else begin
      int c, ill, sel, anyact;
      c = mdecode(m_pwr, cs_n, ras_n, cas_n, we_n, cke_prev, cke, addr[10]);
      sel = int'(ba);
      anyact = 0;
      for (int b = 0; b < NB; b++) anyact += m_act[b];
      ill = (m_pwr == 1 && !cke_prev && cke && c == 14) ? 1 : 0;
      if (c == 2 && m_act[sel] != 0) ill = 1;
      if (c >= 3 && c <= 6 && m_act[sel] == 0) ill = 1;
      if (c == 10 && anyact != 0) ill = 1;
      if (cke_prev && m_pwr != 1)
        for (int b = 0; b < NB; b++)
          if (m_cnt[b] > 0) begin
            m_cnt[b]--;
            if (m_cnt[b] == 0) m_act[b] = 0;
          end
      if (c == 2 && ill == 0) begin m_act[sel] = 1; m_row[sel] = int'(addr); m_cnt[sel] = 0; end
      if ((c == 4 || c == 6) && ill == 0) begin m_act[sel] = 1; m_cnt[sel] = BL; end
      if (c == 7) begin m_act[sel] = 0; m_cnt[sel] = 0; end
      if (c == 8 || c == 11 || c == 12)
        for (int b = 0; b < NB; b++) begin m_act[b] = 0; m_cnt[b] = 0; end
      if (m_pwr == 1) begin
        if (c == 13) m_pwr = 0;
      end else if (c == 12) m_pwr = 1;
      else m_pwr = cke ? 0 : 2;
      m_cmd = c;
      m_ill = ill;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    logic [NB-1:0] ea;
    logic [NB*RW-1:0] er;
    for (int b = 0; b < NB; b++) begin
      ea[b] = (m_act[b] != 0);
      er[b*RW +: RW] = RW'(m_row[b]);
    end
    chk("R2 cmd_q vs model", cmd_q, m_cmd);
    chk("R8 illegal_q vs model", illegal_q, m_ill);
    chk("R5 bank_active vs model", bank_active, ea);
    chk("R6 open_rows vs model", open_rows, er);
    chk("R11 pwr_q vs model", pwr_q, m_pwr);
  endtask

  // one cycle of stimulus; the outputs of the previous edge are compared first
  task automatic cyc(logic cs, logic r, logic c, logic w, logic ck, int b, int a);
    @(negedge clk);
    if (!rst) compare_model();
    cke_prev = cke;
    cke = ck;
    cs_n = cs; ras_n = r; cas_n = c; we_n = w;
    ba = 2'(b); addr = RW'(a);
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic nop1();
    cyc(0, 1, 1, 1, 1, 0, 0);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset bank_active", bank_active, 0);
    chk("R12 reset pwr_q", pwr_q, 0);
    chk("R12 reset cmd_q", cmd_q, 0);
    chk("R12 reset open_rows", open_rows, 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: deselect masks an activate pattern
    cyc(1, 0, 1, 1, 1, 2, 12'h555); settle();
    chk("R1 deselect code", cmd_q, 0);
    chk("R1 deselect no bank", bank_active, 0);

    // R6: activate bank 2
    cyc(0, 0, 1, 1, 1, 2, 12'hABC); settle();
    chk("R6 act code", cmd_q, 2);
    chk("R6 bank2 active", bank_active, 4'b0100);
    chk("R6 bank2 row", open_rows[2*RW +: RW], 12'hABC);

    // R8: activate to active bank, read to idle bank
    cyc(0, 0, 1, 1, 1, 2, 12'h111); settle();
    chk("R8 act active illegal", illegal_q, 1);
    chk("R8 row unchanged", open_rows[2*RW +: RW], 12'hABC);
    cyc(0, 1, 0, 1, 1, 1, 0); settle();
    chk("R8 read idle illegal", illegal_q, 1);
    chk("R8 read idle no open", bank_active, 4'b0100);

    // R2: further encodings
    cyc(0, 1, 0, 1, 1, 2, 0); settle();
    chk("R2 read code", cmd_q, 3);
    chk("R2 read legal", illegal_q, 0);
    cyc(0, 1, 0, 0, 1, 2, 0); settle();
    chk("R2 write code", cmd_q, 5);
    cyc(0, 1, 1, 0, 1, 0, 0); settle();
    chk("R2 terminate code", cmd_q, 9);
    nop1();
    chk("R2 nop code", cmd_q, 1);

    // R9: mode register set with a bank open
    cyc(0, 0, 0, 0, 1, 0, 0); settle();
    chk("R9 mrs busy illegal", illegal_q, 1);

    // R5: single precharge, then precharge-all
    cyc(0, 0, 1, 1, 1, 0, 12'h123); settle();
    cyc(0, 0, 1, 0, 1, 2, 0); settle();
    chk("R5 pre code", cmd_q, 7);
    chk("R5 pre only bank2", bank_active, 4'b0001);
    cyc(0, 0, 1, 1, 1, 3, 12'h0F0); settle();
    cyc(0, 0, 1, 0, 1, 1, 12'h400); settle();
    chk("R5 prea code", cmd_q, 8);
    chk("R5 prea all idle", bank_active, 0);

    // R9: legal mode register set
    cyc(0, 0, 0, 0, 1, 0, 12'h032); settle();
    chk("R9 mrs code", cmd_q, 10);
    chk("R9 mrs legal", illegal_q, 0);

    // R7: read with auto-precharge closes the bank after BL edges
    cyc(0, 0, 1, 1, 1, 1, 12'h777); settle();
    cyc(0, 1, 0, 1, 1, 1, 12'h400); settle();
    chk("R7 reada code", cmd_q, 4);
    for (int i = 1; i < BL; i++) nop1();
    chk("R7 still active at BL-1", bank_active[1], 1);
    nop1();
    chk("R7 idle after BL", bank_active[1], 0);

    // R10: auto-refresh closes banks
    cyc(0, 0, 1, 1, 1, 0, 1); settle();
    cyc(0, 0, 1, 1, 1, 3, 2); settle();
    cyc(0, 0, 0, 1, 1, 0, 0); settle();
    chk("R10 refa code", cmd_q, 11);
    chk("R10 refa all idle", bank_active, 0);

    // R3: self-refresh entry
    cyc(0, 0, 1, 1, 1, 1, 5); settle();
    cyc(0, 0, 0, 1, 0, 0, 0); settle();
    chk("R3 refs code", cmd_q, 12);
    chk("R3 self state", pwr_q, 1);
    chk("R10 refs all idle", bank_active, 0);

    // R4: hold, bad exit, good exit
    cyc(0, 0, 1, 1, 0, 0, 0); settle();
    chk("R4 held code", cmd_q, 14);
    chk("R4 still self", pwr_q, 1);
    cyc(0, 0, 1, 1, 1, 0, 0); settle();
    chk("R4 bad exit illegal", illegal_q, 1);
    chk("R4 bad exit stays", pwr_q, 1);
    chk("R4 bad exit no open", bank_active, 0);
    cyc(1, 1, 1, 1, 0, 0, 0); settle();
    cyc(0, 1, 1, 1, 1, 0, 0); settle();
    chk("R4 exit code", cmd_q, 13);
    chk("R4 exit normal", pwr_q, 0);

    // R11: clock suspend ignores commands
    cyc(0, 1, 1, 1, 0, 0, 0); settle();
    chk("R11 suspend state", pwr_q, 2);
    cyc(0, 0, 1, 1, 1, 0, 12'h222); settle();
    chk("R11 held code", cmd_q, 14);
    chk("R11 act ignored", bank_active, 0);
    chk("R11 resume", pwr_q, 0);

    // pseudo-random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic ck;
      if (m_pwr == 1) ck = ($urandom_range(0, 3) == 0);
      else            ck = ($urandom_range(0, 9) != 0);
      cyc(($urandom_range(0, 4) == 0), 1'($urandom), 1'($urandom), 1'($urandom),
          ck, $urandom_range(0, NB-1), $urandom_range(0, 4095));
    end
    cyc(1, 1, 1, 1, 1, 0, 0);
    cyc(1, 1, 1, 1, 1, 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule